// File: doc/BRIEF.md
# DMA Stream Packing FIFO

This block is the data buffer of one DMA stream. It sits between the side that reads source items and the side that writes destination items. Its storage is four 32-bit words, held internally as a ring of bytes. In buffered mode the source and destination item widths are chosen independently as byte, halfword or word. Narrow source items are packed into wider destination items, and wide items are split into narrow ones, always least significant byte first. A programmable fill threshold tells the stream engine when enough data is buffered to start draining.

In pass-through mode the block holds at most one full 32-bit item, and the width settings are ignored. When the stream moves data from memory to a peripheral, a fetch request asks for one item to be loaded ahead of time. The item is then ready the moment the peripheral asks for it.

A push with too little room and a pop with too little data are ignored. Each one sets a sticky error flag, and buffered mode and pass-through mode have separate flags. Each flag is cleared by a one-cycle clear pulse.

Top module: `dsf_fifo`

## Requirements
- R1: After reset the block is empty. pop_valid_o, drain_req_o, fifo_err_o and dmode_err_o are all 0, and fetch_req_o is 0 while direct_mode_i is 0.
- R2: In buffered mode, byte items (size code 0) are packed little-endian: the first byte pushed appears on pop_data_o[7:0] of a word pop (size code 2). Only push_data_i[7:0] is used for a byte push, and only push_data_i[15:0] for a halfword push (size code 1).
- R3: A word pushed and popped as bytes comes out as bits 7:0 first, then 15:8, 23:16 and 31:24. Bits of pop_data_o above the destination item width read as zero.
- R4: Items of equal width come out in push order, and buffered mode holds 16 bytes in total.
- R5: pop_valid_o is 1 exactly when the stored byte count is at least the destination item size. In pass-through mode that size is 4 bytes.
- R6: In buffered mode drain_req_o is 1 while the stored byte count is at least the threshold set by thresh_i (0: 4 bytes, 1: 8, 2: 12, 3: 16). It is 0 below that count and always 0 in pass-through mode.
- R7: A buffered-mode push with fewer free bytes than the source item size stores nothing and sets fifo_err_o.
- R8: A buffered-mode pop with fewer stored bytes than the destination item size removes nothing and sets fifo_err_o.
- R9: In buffered mode, size code 3 on either width input is an illegal level setting and sets fifo_err_o.
- R10: fifo_err_o and dmode_err_o stay set until their clear input pulses. If a new error and a clear arrive in the same cycle, the flag stays set.
- R11: In pass-through mode one full 32-bit item is stored and returned unchanged, whatever the width inputs say.
- R12: In pass-through mode, a push while an item is held, or a pop while empty, is ignored and sets dmode_err_o, not fifo_err_o.
- R13: fetch_req_o is 1 exactly when pass-through mode is on, mem_to_periph_i is 1 and nothing is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| direct_mode_i | input | 1 | 1 selects pass-through mode, 0 selects buffered mode |
| mem_to_periph_i | input | 1 | Stream direction is memory to peripheral |
| src_size_i | input | 2 | Source item size: 0 byte, 1 halfword, 2 word, 3 illegal |
| dst_size_i | input | 2 | Destination item size, same coding |
| thresh_i | input | 2 | Drain threshold: 0 quarter, 1 half, 2 three quarters, 3 full |
| push_i | input | 1 | Push one source item |
| push_data_i | input | 32 | Source item, right aligned |
| pop_i | input | 1 | Pop one destination item |
| pop_data_o | output | 32 | Destination item at the head, zero extended |
| pop_valid_o | output | 1 | A whole destination item is available |
| drain_req_o | output | 1 | Fill level has reached the threshold |
| fetch_req_o | output | 1 | Request to load one item ahead in pass-through mode |
| clr_fifo_err_i | input | 1 | Clear pulse for fifo_err_o |
| clr_dmode_err_i | input | 1 | Clear pulse for dmode_err_o |
| fifo_err_o | output | 1 | Sticky buffered-mode error |
| dmode_err_o | output | 1 | Sticky pass-through error |

## Verification
The bench builds the block with NUM_WORDS at its default of 4, which gives a 16-byte ring. With that size a handful of pushes reaches every threshold, and each threshold sits at a distinct level (4, 8, 12 and 16 bytes). Overflow with halfword items and read-pointer wraparound also come within a few dozen cycles. A byte-level scoreboard models packing independently of the RTL, so mixed width pairs and the pass-through path are all compared against the same reference.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } item_sz_e;

  function automatic logic [2:0] sz_bytes(input logic [1:0] s);
    case (item_sz_e'(s))
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dsf_store.sv
module dsf_store #(
  parameter int unsigned CAP_BYTES = 16,
  parameter int unsigned PW        = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] wptr_i,
  input  logic [2:0]    wcnt_i,
  input  logic [31:0]   wdata_i,
  input  logic [PW-1:0] rptr_i,
  input  logic [2:0]    rcnt_i,
  output logic [31:0]   rdata_o
);
  logic [7:0] mem [CAP_BYTES];

  for (genvar j = 0; j < CAP_BYTES; j++) begin : g_byte
    logic [PW-1:0] off;
    logic [7:0]    byte_q;
    // lane offset of this byte relative to the write pointer
    assign off = PW'(j) - wptr_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  byte_q <= 8'h00;
      else if (we_i && (32'(off) < 32'(wcnt_i)))    byte_q <= wdata_i[8*off[1:0] +: 8];
    end
    assign mem[j] = byte_q;
  end

  for (genvar k = 0; k < dsf_pkg::LANES; k++) begin : g_rd
    logic [PW-1:0] ra;
    assign ra = rptr_i + PW'(k);
    assign rdata_o[8*k +: 8] = (32'(k) < 32'(rcnt_i)) ? mem[ra] : 8'h00;
  end
endmodule

// File: rtl/dsf_ctrl.sv
module dsf_ctrl #(
  parameter int unsigned CAP_BYTES = 16,
  parameter int unsigned PW        = 4,
  parameter int unsigned LW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          direct_i,
  input  logic          size_bad_i,
  input  logic          push_i,
  input  logic [2:0]    wcnt_i,
  input  logic          pop_i,
  input  logic [2:0]    rcnt_i,
  input  logic          clr_fifo_err_i,
  input  logic          clr_dmode_err_i,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] rptr_o,
  output logic [LW-1:0] level_o,
  output logic          push_ok_o,
  output logic          pop_ok_o,
  output logic          fifo_err_o,
  output logic          dmode_err_o
);
  localparam logic [LW-1:0] CAP_L    = LW'(CAP_BYTES);
  localparam logic [LW-1:0] DIRECT_L = LW'(dsf_pkg::LANES);

  logic [PW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] level_q, level_d, cap_eff, free_b;
  logic          ferr_q, derr_q, ferr_set, derr_set;
  logic          push_rej, pop_rej;

  assign cap_eff   = direct_i ? DIRECT_L : CAP_L;
  assign free_b    = (level_q >= cap_eff) ? '0 : cap_eff - level_q;
  assign push_ok_o = push_i && (free_b >= LW'(wcnt_i));
  assign pop_ok_o  = pop_i && (level_q >= LW'(rcnt_i));
  assign push_rej  = push_i && !push_ok_o;
  assign pop_rej   = pop_i && !pop_ok_o;

  assign ferr_set = !direct_i && (push_rej || pop_rej || size_bad_i);
  assign derr_set = direct_i && (push_rej || pop_rej);

  always_comb begin
    level_d = level_q;
    if (push_ok_o) level_d = level_d + LW'(wcnt_i);
    if (pop_ok_o)  level_d = level_d - LW'(rcnt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
      ferr_q  <= 1'b0;
      derr_q  <= 1'b0;
    end else begin
      if (push_ok_o) wptr_q <= wptr_q + PW'(wcnt_i);
      if (pop_ok_o)  rptr_q <= rptr_q + PW'(rcnt_i);
      level_q <= level_d;
      ferr_q  <= ferr_set || (ferr_q && !clr_fifo_err_i);
      derr_q  <= derr_set || (derr_q && !clr_dmode_err_i);
    end
  end

  assign wptr_o      = wptr_q;
  assign rptr_o      = rptr_q;
  assign level_o     = level_q;
  assign fifo_err_o  = ferr_q;
  assign dmode_err_o = derr_q;

  assert_level_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= CAP_L);
  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !direct_i && !push_ok_o) |=> fifo_err_o);
  assert_underflow_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !pop_ok_o && !push_ok_o) |=> (level_q == $past(level_q)));
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_err_o && !clr_fifo_err_i) |=> fifo_err_o);
  assert_direct_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct_i && level_q <= DIRECT_L) |=> (level_q <= DIRECT_L));
  assert_dmode_err_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct_i && push_i && !push_ok_o) |=> dmode_err_o);
endmodule

// File: rtl/dsf_thresh.sv
module dsf_thresh #(
  parameter int unsigned CAP_BYTES = 16,
  parameter int unsigned LW        = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          direct_i,
  input  logic [1:0]    thresh_i,
  input  logic [LW-1:0] level_i,
  output logic          drain_req_o
);
  localparam int unsigned QUARTER = CAP_BYTES / 4;

  logic [LW-1:0] thr_b;

  always_comb begin
    case (thresh_i)
      2'd0:    thr_b = LW'(QUARTER);
      2'd1:    thr_b = LW'(2 * QUARTER);
      2'd2:    thr_b = LW'(3 * QUARTER);
      default: thr_b = LW'(CAP_BYTES);
    endcase
  end

  assign drain_req_o = !direct_i && (level_i >= thr_b);

  assert_drain_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i < LW'(QUARTER)) |-> !drain_req_o);
  assert_drain_direct_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    direct_i |-> !drain_req_o);
endmodule

// File: rtl/dsf_fifo.sv
module dsf_fifo #(
  parameter int unsigned NUM_WORDS = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        direct_mode_i,
  input  logic        mem_to_periph_i,
  input  logic [1:0]  src_size_i,
  input  logic [1:0]  dst_size_i,
  input  logic [1:0]  thresh_i,
  input  logic        push_i,
  input  logic [31:0] push_data_i,
  input  logic        pop_i,
  output logic [31:0] pop_data_o,
  output logic        pop_valid_o,
  output logic        drain_req_o,
  output logic        fetch_req_o,
  input  logic        clr_fifo_err_i,
  input  logic        clr_dmode_err_i,
  output logic        fifo_err_o,
  output logic        dmode_err_o
);
  import dsf_pkg::*;

  localparam int unsigned CAP_BYTES = NUM_WORDS * LANES;
  localparam int unsigned PW        = $clog2(CAP_BYTES);
  localparam int unsigned LW        = $clog2(CAP_BYTES + 1);

  logic [2:0]    wcnt, rcnt;
  logic          size_bad;
  logic [PW-1:0] wptr, rptr;
  logic [LW-1:0] level;
  logic          push_ok, pop_ok;

  // pass-through always moves whole words
  assign wcnt     = direct_mode_i ? 3'd4 : sz_bytes(src_size_i);
  assign rcnt     = direct_mode_i ? 3'd4 : sz_bytes(dst_size_i);
  assign size_bad = !direct_mode_i &&
                    (item_sz_e'(src_size_i) == SZ_BAD || item_sz_e'(dst_size_i) == SZ_BAD);

  dsf_ctrl #(.CAP_BYTES(CAP_BYTES), .PW(PW), .LW(LW)) i_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .direct_i        (direct_mode_i),
    .size_bad_i      (size_bad),
    .push_i          (push_i),
    .wcnt_i          (wcnt),
    .pop_i           (pop_i),
    .rcnt_i          (rcnt),
    .clr_fifo_err_i  (clr_fifo_err_i),
    .clr_dmode_err_i (clr_dmode_err_i),
    .wptr_o          (wptr),
    .rptr_o          (rptr),
    .level_o         (level),
    .push_ok_o       (push_ok),
    .pop_ok_o        (pop_ok),
    .fifo_err_o      (fifo_err_o),
    .dmode_err_o     (dmode_err_o)
  );

  dsf_store #(.CAP_BYTES(CAP_BYTES), .PW(PW)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push_ok),
    .wptr_i  (wptr),
    .wcnt_i  (wcnt),
    .wdata_i (push_data_i),
    .rptr_i  (rptr),
    .rcnt_i  (rcnt),
    .rdata_o (pop_data_o)
  );

  dsf_thresh #(.CAP_BYTES(CAP_BYTES), .LW(LW)) i_thresh (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .direct_i    (direct_mode_i),
    .thresh_i    (thresh_i),
    .level_i     (level),
    .drain_req_o (drain_req_o)
  );

  assign pop_valid_o = level >= LW'(rcnt);
  assign fetch_req_o = direct_mode_i && mem_to_periph_i && (level == '0);

  assert_preload_fill_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && push_i) |=> pop_valid_o);
  assert_pop_needs_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !pop_valid_o && !push_i) |=> $stable(level));
endmodule

// File: tb/test_dsf_fifo.sv
module test_dsf_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        direct_mode = 1'b0, m2p = 1'b0;
  logic [1:0]  src_size = 2'd2, dst_size = 2'd2, thresh = 2'd1;
  logic        push = 1'b0, pop = 1'b0;
  logic [31:0] push_data = '0;
  logic        clr_ferr = 1'b0, clr_derr = 1'b0;
  logic [31:0] pop_data;
  logic        pop_valid, drain_req, fetch_req, fifo_err, dmode_err;

  int unsigned total = 0, bad = 0;
  logic [7:0]  exp_q [$];
  string       cur_req = "R4";

  always #2 clk = ~clk;

  dsf_fifo #(.NUM_WORDS(4)) i_dsf_fifo (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .direct_mode_i   (direct_mode),
    .mem_to_periph_i (m2p),
    .src_size_i      (src_size),
    .dst_size_i      (dst_size),
    .thresh_i        (thresh),
    .push_i          (push),
    .push_data_i     (push_data),
    .pop_i           (pop),
    .pop_data_o      (pop_data),
    .pop_valid_o     (pop_valid),
    .drain_req_o     (drain_req),
    .fetch_req_o     (fetch_req),
    .clr_fifo_err_i  (clr_ferr),
    .clr_dmode_err_i (clr_derr),
    .fifo_err_o      (fifo_err),
    .dmode_err_o     (dmode_err)
  );

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: pushes and records the expected bytes once the edge has taken them
  task automatic push_item(input logic [31:0] d);
    int nb, cap;
    bit acc;
    @(posedge clk); #1;
    nb  = direct_mode ? 4 : nbytes(src_size);
    cap = direct_mode ? 4 : 16;
    acc = (exp_q.size() + nb) <= cap;
    push = 1'b1; push_data = d;
    @(posedge clk); #1;
    push = 1'b0;
    if (acc) for (int k = 0; k < nb; k++) exp_q.push_back(d[8*k +: 8]);
  endtask

  task automatic pop_item();
    @(posedge clk); #1;
    pop = 1'b1;
    @(posedge clk); #1;
    pop = 1'b0;
  endtask

  task automatic pulse_clr(input bit which_d);
    @(posedge clk); #1;
    if (which_d) clr_derr = 1'b1; else clr_ferr = 1'b1;
    @(posedge clk); #1;
    clr_derr = 1'b0; clr_ferr = 1'b0;
  endtask

  // monitor: compares valid and popped items against the byte scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      int db;
      logic [31:0] exp;
      db = direct_mode ? 4 : nbytes(dst_size);
      check(pop_valid == (exp_q.size() >= db), "R5 pop_valid", 32'(pop_valid), 32'(exp_q.size() >= db));
      if (pop && pop_valid && exp_q.size() >= db) begin
        exp = '0;
        for (int k = 0; k < db; k++) exp[8*k +: 8] = exp_q.pop_front();
        check(pop_data == exp, cur_req, pop_data, exp);
      end
    end
  end

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!pop_valid, "R1 pop_valid", 32'(pop_valid), 0);
    check(!drain_req, "R1 drain", 32'(drain_req), 0);
    check(!fifo_err && !dmode_err, "R1 errors", {fifo_err, dmode_err}, 0);
    check(!fetch_req, "R1 fetch", 32'(fetch_req), 0);

    // R2 byte packing, R6 half threshold
    cur_req = "R2 packing";
    src_size = 2'd0; dst_size = 2'd2; thresh = 2'd1;
    push_item(32'hFFFFFF11); push_item(32'hEEEEEE22); push_item(32'hDDDDDD33);
    @(negedge clk);
    check(!pop_valid, "R5 three bytes", 32'(pop_valid), 0);
    push_item(32'hCCCCCC44);
    @(negedge clk);
    check(pop_valid, "R5 four bytes", 32'(pop_valid), 1);
    check(!drain_req, "R6 below half", 32'(drain_req), 0);
    push_item(32'h55); push_item(32'h66); push_item(32'h77); push_item(32'h88);
    @(negedge clk);
    check(drain_req, "R6 at half", 32'(drain_req), 1);
    pop_item();
    @(negedge clk);
    check(!drain_req, "R6 back below", 32'(drain_req), 0);
    pop_item();

    // R3 unpacking
    cur_req = "R3 unpacking";
    src_size = 2'd2; dst_size = 2'd0;
    push_item(32'hA1B2C3D4);
    for (int i = 0; i < 4; i++) pop_item();
    @(negedge clk);
    check(!pop_valid, "R3 drained", 32'(pop_valid), 0);

    // R4 order and capacity, R7 overflow, R10 sticky clear
    cur_req = "R4 order";
    src_size = 2'd1; dst_size = 2'd1; thresh = 2'd3;
    for (int i = 0; i < 8; i++) push_item(32'hABCD0000 | 32'(16'h1000 + i));
    @(negedge clk);
    check(drain_req, "R6 full", 32'(drain_req), 1);
    check(!fifo_err, "R4 no error at 16 bytes", 32'(fifo_err), 0);
    push_item(32'h0000BEEF);
    @(negedge clk);
    check(fifo_err, "R7 overflow flag", 32'(fifo_err), 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fifo_err, "R10 sticky", 32'(fifo_err), 1);
    pulse_clr(1'b0);
    @(negedge clk);
    check(!fifo_err, "R10 cleared", 32'(fifo_err), 0);
    for (int i = 0; i < 8; i++) pop_item();

    // R8 underflow
    pop_item();
    @(negedge clk);
    check(fifo_err, "R8 underflow flag", 32'(fifo_err), 1);
    check(!pop_valid, "R8 still empty", 32'(pop_valid), 0);
    check(!dmode_err, "R8 no direct error", 32'(dmode_err), 0);
    pulse_clr(1'b0);

    // R9 illegal size code
    @(posedge clk); #1 src_size = 2'd3;
    @(posedge clk); #1 src_size = 2'd2;
    @(negedge clk);
    check(fifo_err, "R9 illegal size", 32'(fifo_err), 1);
    pulse_clr(1'b0);
    @(negedge clk);
    check(!fifo_err, "R10 cleared again", 32'(fifo_err), 0);

    // R6 quarter and three-quarter thresholds
    cur_req = "R4 words";
    dst_size = 2'd2; thresh = 2'd0;
    push_item(32'h01020304);
    @(negedge clk);
    check(drain_req, "R6 quarter", 32'(drain_req), 1);
    @(posedge clk); #1 thresh = 2'd2;
    push_item(32'h05060708);
    @(negedge clk);
    check(!drain_req, "R6 below three quarters", 32'(drain_req), 0);
    push_item(32'h090A0B0C);
    @(negedge clk);
    check(drain_req, "R6 three quarters", 32'(drain_req), 1);
    for (int i = 0; i < 3; i++) pop_item();

    // R11 R12 R13 pass-through
    cur_req = "R11 pass-through";
    @(posedge clk); #1 direct_mode = 1'b1; m2p = 1'b1; src_size = 2'd0; dst_size = 2'd0;
    @(negedge clk);
    check(fetch_req, "R13 fetch when empty", 32'(fetch_req), 1);
    push_item(32'hCAFEF00D);
    @(negedge clk);
    check(!fetch_req, "R13 no fetch when held", 32'(fetch_req), 0);
    check(!drain_req, "R6 off in direct", 32'(drain_req), 0);
    push_item(32'h12345678);
    @(negedge clk);
    check(dmode_err, "R12 push while held", 32'(dmode_err), 1);
    check(!fifo_err, "R12 buffered flag untouched", 32'(fifo_err), 0);
    pop_item();
    @(negedge clk);
    check(fetch_req, "R13 fetch after pop", 32'(fetch_req), 1);
    pulse_clr(1'b1);
    @(negedge clk);
    check(!dmode_err, "R10 direct clear", 32'(dmode_err), 0);
    pop_item();
    @(negedge clk);
    check(dmode_err, "R12 pop while empty", 32'(dmode_err), 1);
    check(!fifo_err, "R12 no buffered error", 32'(fifo_err), 0);
    pulse_clr(1'b1);
    @(posedge clk); #1 m2p = 1'b0;
    @(negedge clk);
    check(!fetch_req, "R13 no fetch toward memory", 32'(fetch_req), 0);

    @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule